// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that software must feed with a two-step key sequence. A 16-bit down-counter steps once per tick-enable pulse while the watchdog is enabled. To reload it, software writes a first key (0x556C) and then a second key (0xAA39) to a write-only service register. Other bus cycles may fall between the two key writes. Any other value written to the service register throws away a half-finished sequence.

When the counter runs down to zero before it has been fed, the block raises one of two latched requests: a reset request or an interrupt request. A mode bit in the control register picks which one. The control register also holds the enable bit and the 16-bit reload value. A read-only count register shows the live counter. All three registers sit on a simple synchronous bus: a write strobe, a read strobe and a 2-bit word index. Read data comes back registered, one cycle after the read strobe.

Register map (word index on `bus_addr`): 0 = control, 1 = count, 2 = service, 3 = unused (reads zero). Control write/read layout: bits [15:0] reload value, bit 16 enable, bit 17 mode (1 = interrupt, 0 = reset).

Top module: `wdog_keyed`

## Requirements
- R1: After reset the counter is 0xFFFF, the control register reads 0x0000FFFF (reload 0xFFFF, disabled, reset mode), and both request outputs are low.
- R2: The counter falls by one on each cycle with `tick_en` high while enabled. Without a tick, or while disabled, it holds its value.
- R3: Writing 0x556C and then 0xAA39 to the service register (index 2) reloads the counter from the reload field on the edge of the second write. Unrelated bus cycles and ticks between the two writes do not break the sequence.
- R4: A service write of any value other than the two keys cancels a pending first key, so a following 0xAA39 alone does not reload the counter.
- R5: A 0xAA39 written while no first key is pending does not reload the counter.
- R6: Writing 0x556C again while the first key is already pending keeps the sequence pending, so a following 0xAA39 completes it.
- R7: In reset mode (bit 17 = 0), the tick that moves the counter from 1 to 0 sets `wdt_rst_req`. It then stays high until reset, even after a later completed service, and `wdt_irq` stays low.
- R8: In interrupt mode (bit 17 = 1), the tick that moves the counter from 1 to 0 sets `wdt_irq`, with `wdt_rst_req` low. A completed service clears `wdt_irq` and reloads the counter.
- R9: Reading index 1 returns the counter in bits [15:0] and zero in bits [31:16]. Writes to index 1 change nothing.
- R10: Reading the service register (index 2) always returns zero.
- R11: The counter never wraps below zero. Further ticks at zero leave it at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-step enable pulse |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 18 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| wdt_rst_req | output | 1 | Latched reset request on expiry |
| wdt_irq | output | 1 | Latched interrupt request on expiry |

## Verification
The bench targets the sequence corner cases:
- A bad value between the two keys. A checker that fails to clear the pending state would reload the counter anyway.
- A lone second key. A checker that ignores which state it is in would reload the counter.
- A repeated first key. A design that returns to idle on it would miss the next valid service.

It also checks that the reload lands exactly on the edge of the second key write, with a tick and a read placed between the two keys. Expiry is driven in both modes. This catches a wrong request line, a reset request that a later service wrongly clears, an interrupt that a service fails to clear, and a counter that wraps past zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 2;
  localparam int WDATA_W = CNT_W + 2;
  localparam int RDATA_W = 32;

  localparam logic [CNT_W-1:0] KEY_A = 16'h556C;
  localparam logic [CNT_W-1:0] KEY_B = 16'hAA39;

  localparam logic [ADDR_W-1:0] IDX_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] IDX_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] IDX_SVC  = 2'd2;

  localparam int BIT_EN   = CNT_W;
  localparam int BIT_MODE = CNT_W + 1;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ARMED = 1'b1} seq_t;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
#(
  parameter int W = CNT_W,
  parameter logic [W-1:0] K1 = KEY_A,
  parameter logic [W-1:0] K2 = KEY_B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] val,
  output logic         svc_ok,
  output logic         armed
);
  seq_t state_q;

  assign armed  = (state_q == SEQ_ARMED);
  assign svc_ok = wr && armed && (val == K2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else if (wr) begin
      if (val == K1) state_q <= SEQ_ARMED;
      else           state_q <= SEQ_IDLE;
    end
  end

  assert_bad_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && val != K1 && val != K2) |=> !armed);
  assert_k1_arms_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && val == K1) |=> armed);
  assert_lone_k2_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && !armed && val == K2) |=> !armed);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         irq_mode,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         rst_req,
  output logic         irq
);
  localparam logic [W-1:0] INIT = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic         rst_req_q, irq_q;
  logic         step, expire;

  assign step   = en && tick && (cnt_q != '0);
  assign expire = en && tick && (cnt_q <= ONE) && !load && !(rst_req_q || irq_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= INIT;
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (load)      cnt_q <= load_val;
      else if (step) cnt_q <= cnt_q - ONE;
      if (expire && !irq_mode) rst_req_q <= 1'b1;
      if (expire && irq_mode)  irq_q <= 1'b1;
      else if (load)           irq_q <= 1'b0;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = rst_req_q;
  assign irq     = irq_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && !(en && tick)) |=> $stable(cnt_q));
  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> cnt_q == '0);
  assert_rst_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |=> rst_req_q);
  assert_one_req_R8: assert property (@(posedge clk) disable iff (rst)
    !(rst_req_q && irq_q));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WDATA_W-1:0] bus_wdata,
  output logic [RDATA_W-1:0] bus_rdata,
  output logic               wdt_rst_req,
  output logic               wdt_irq
);
  localparam int PAD_CNT  = RDATA_W - CNT_W;
  localparam int PAD_CTRL = RDATA_W - WDATA_W;

  logic [CNT_W-1:0]   reload_q;
  logic               en_q, mode_q;
  logic               svc_wr, svc_ok, armed;
  logic [CNT_W-1:0]   cnt;
  logic [RDATA_W-1:0] rdata_q;

  assign svc_wr = bus_we && (bus_addr == IDX_SVC);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= {CNT_W{1'b1}};
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
    end else if (bus_we && bus_addr == IDX_CTRL) begin
      reload_q <= bus_wdata[CNT_W-1:0];
      en_q     <= bus_wdata[BIT_EN];
      mode_q   <= bus_wdata[BIT_MODE];
    end
  end

  wdog_key_seq #(.W(CNT_W), .K1(KEY_A), .K2(KEY_B)) u_seq (
    .clk(clk), .rst(rst), .wr(svc_wr), .val(bus_wdata[CNT_W-1:0]),
    .svc_ok(svc_ok), .armed(armed)
  );

  wdog_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .tick(tick_en), .irq_mode(mode_q),
    .load(svc_ok), .load_val(reload_q), .cnt(cnt),
    .rst_req(wdt_rst_req), .irq(wdt_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        IDX_CTRL: rdata_q <= {{PAD_CTRL{1'b0}}, mode_q, en_q, reload_q};
        IDX_CNT:  rdata_q <= {{PAD_CNT{1'b0}}, cnt};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  assert_cnt_upper_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == IDX_CNT) |=> bus_rdata[RDATA_W-1:CNT_W] == '0);
  assert_svc_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == IDX_SVC) |=> bus_rdata == '0);
  assert_armed_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && !svc_wr) |=> armed);
endmodule

// File: tb/wdog_keyed_tb.sv
`timescale 1ns/1ps
module wdog_keyed_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [17:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req, wdt_irq;

  int n_checks = 0;
  int n_fail = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  wdog_keyed u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the registered result is present
  always @(posedge clk) rd_pend <= bus_re;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard: unexpected read data %h", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [17:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_re = 1'b1; bus_addr = a;
    cyc();
    bus_re = 1'b0;
    cyc();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      cyc();
    end
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
  endtask

  task automatic service();
    wr(2'd2, 18'h0556C);
    wr(2'd2, 18'h0AA39);
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 rst_req", {31'b0, wdt_rst_req}, 32'h0);
    check("R1 irq", {31'b0, wdt_irq}, 32'h0);
    rd(2'd0, 32'h0000FFFF, "R1 ctrl");
    rd(2'd1, 32'h0000FFFF, "R1 count");
    rd(2'd2, 32'h0, "R10 service read");
    // R2 ticks while disabled do nothing
    ticks(3);
    rd(2'd1, 32'h0000FFFF, "R2 disabled hold");
    // enable, reset mode, reload 0x0010
    wr(2'd0, 18'h10010);
    rd(2'd0, 32'h00010010, "R1 ctrl writeback");
    ticks(3);
    rd(2'd1, 32'h0000FFFC, "R2 decrement");
    repeat (4) cyc();
    rd(2'd1, 32'h0000FFFC, "R2 no tick hold");
    // R9 count writes ignored
    wr(2'd1, 18'h01234);
    rd(2'd1, 32'h0000FFFC, "R9 count write ignored");
    // R3 keys with other traffic and a tick in between
    wr(2'd2, 18'h0556C);
    rd(2'd0, 32'h00010010, "R3 read between keys");
    ticks(1);
    wr(2'd2, 18'h0AA39);
    rd(2'd1, 32'h00000010, "R3 reload");
    ticks(1);
    rd(2'd1, 32'h0000000F, "R2 after reload");
    // R4 bad value cancels
    wr(2'd2, 18'h0556C); wr(2'd2, 18'h01234); wr(2'd2, 18'h0AA39);
    rd(2'd1, 32'h0000000F, "R4 cancelled");
    // R5 lone second key
    wr(2'd2, 18'h0AA39);
    rd(2'd1, 32'h0000000F, "R5 lone key2");
    // R6 repeated first key
    wr(2'd2, 18'h0556C); wr(2'd2, 18'h0556C); wr(2'd2, 18'h0AA39);
    rd(2'd1, 32'h00000010, "R6 repeated key1");
    // R7 expiry in reset mode
    ticks(15);
    rd(2'd1, 32'h00000001, "R7 count at one");
    check("R7 not yet", {31'b0, wdt_rst_req}, 32'h0);
    ticks(1);
    check("R7 rst_req set", {31'b0, wdt_rst_req}, 32'h1);
    check("R7 irq low", {31'b0, wdt_irq}, 32'h0);
    ticks(2);
    rd(2'd1, 32'h00000000, "R11 no wrap");
    service();
    rd(2'd1, 32'h00000010, "R7 service reloads");
    check("R7 rst_req sticky", {31'b0, wdt_rst_req}, 32'h1);
    // R8 interrupt mode
    do_reset();
    wr(2'd0, 18'h30004);
    service();
    rd(2'd1, 32'h00000004, "R8 reload 4");
    ticks(3);
    check("R8 irq not yet", {31'b0, wdt_irq}, 32'h0);
    ticks(1);
    check("R8 irq set", {31'b0, wdt_irq}, 32'h1);
    check("R8 rst_req low", {31'b0, wdt_rst_req}, 32'h0);
    rd(2'd1, 32'h00000000, "R8 count zero");
    wr(2'd2, 18'h0556C);
    check("R8 irq after key1", {31'b0, wdt_irq}, 32'h1);
    wr(2'd2, 18'h0AA39);
    check("R8 irq cleared", {31'b0, wdt_irq}, 32'h0);
    rd(2'd1, 32'h00000004, "R8 service reloads");
    rd(2'd2, 32'h0, "R10 service read later");
    repeat (3) cyc();
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule